// File: doc/BRIEF.md
# MSI Capability Register Structure

This block holds the message-signalled-interrupt capability registers of a configuration space. Its dword offsets are counted from the capability base. Three options are fixed at elaboration: the number of vectors the function can raise, whether the message address is 64 bits wide, and whether each vector has its own mask bit. Any vector count other than 1, 2, 4, 8, 16 or 32 stops elaboration with an error.

Configuration software reaches the registers through one port. The port carries a dword index, a write strobe, four byte enables and write data. The read data is combinational from the index. Each register bit has a write mask, so read-only bits keep their value whatever is written.

The block drives the programmed message address, the message data, the enable bit, the number of allocated vectors and the mask bits to a message generator beside it.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 reads 0x05 in bits [7:0] and NEXT_PTR in bits [15:8]. Bits [19:17] read log2 of VEC_COUNT, bit 23 reads 1 exactly when ADDR64 is set, and bit 24 reads 1 exactly when PVMASK is set. Bits [31:25] read zero. Writes change none of these bits.
- R2: In dword 0 only bit 16 (enable) and bits [22:20] (allocated size, log2) are writable. Both read zero after reset.
- R3: Dword 1 is the low message address. Bits [31:2] are writable and reset to zero. Bits [1:0] always read zero.
- R4: With ADDR64 set, dword 2 is the high message address. It is fully writable and resets to zero.
- R5: The message data sits in bits [15:0] of dword 3 when ADDR64 is set, and of dword 2 otherwise. Those bits are fully writable and reset to zero. Bits [31:16] of that dword read zero.
- R6: With PVMASK set, the mask dword follows the data dword. Its bits 0 to VEC_COUNT-1 are writable and reset to zero. Its higher bits read zero.
- R7: The pending dword follows the mask dword. It reads zero and ignores writes. Every dword index with no register behind it reads zero.
- R8: A write changes only the bytes whose byte enable is set. Bytes whose enable is clear keep their value.
- R9: The outputs follow the registers from the clock edge after a write:
  - msg_addr is the high dword (zero without ADDR64) above the low dword.
  - msg_data is the data field.
  - msi_enable is dword 0 bit 16.
  - mask_bits is the mask dword (zero without PVMASK).
- R10: alloc_count equals 2 raised to the smaller of the allocated-size field and log2 of VEC_COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | ADDR_W | Dword index from the capability base |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the indexed dword |
| msg_addr | output | 64 | Programmed message address |
| msg_data | output | 16 | Programmed message data |
| msi_enable | output | 1 | Enable bit |
| alloc_count | output | 6 | Number of allocated vectors |
| mask_bits | output | 32 | Per-vector mask bits |

## Verification
The assertions assume that cfg_wr, cfg_be and cfg_addr are always known values, and that a write lasts one cycle with its data held for that cycle. The bench changes every input only on the falling clock edge, so each write lands cleanly on one rising edge. Its writes cover every dword index, including the pending and unused ones, and use all-ones data, full and partial byte enables, and pseudo-random data. Every value of the allocated-size field is written, including those above the capable size.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
   localparam int DW = 32;

   function automatic int f_log2(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      return r;
   endfunction

   function automatic logic [DW-1:0] f_vec_mask(input int n);
      return (n >= 32) ? '1 : DW'((64'd1 << n) - 64'd1);
   endfunction

   function automatic bit f_count_ok(input int n);
      return (n == 1) || (n == 2) || (n == 4) || (n == 8) || (n == 16) || (n == 32);
   endfunction

   localparam logic [DW-1:0] CTL_WMASK = 32'h0071_0000;
   localparam logic [DW-1:0] ALO_WMASK = 32'hFFFF_FFFC;
   localparam logic [DW-1:0] AHI_WMASK = 32'hFFFF_FFFF;
   localparam logic [DW-1:0] DAT_WMASK = 32'h0000_FFFF;
endpackage

// File: rtl/msi_cap_wreg.sv
module msi_cap_wreg #(
   parameter int               W     = 32,
   parameter logic [W-1:0]     WMASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [W/8-1:0]   be,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     q
);
   localparam int NB = W / 8;

   initial begin
      assert (W % 8 == 0) else $error("register width must be whole bytes");
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam logic [7:0] M = WMASK[b*8 +: 8];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[b*8 +: 8] <= '0;
         else if (we && be[b])
            q[b*8 +: 8] <= (q[b*8 +: 8] & ~M) | (wdata[b*8 +: 8] & M);
      end

      // R8: a byte not enabled for write keeps its value
      a_r8_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && be[b]) |=> $stable(q[b*8 +: 8]));
   end
endmodule

// File: rtl/msi_cap_rdmux.sv
module msi_cap_rdmux #(
   parameter int ADDR_W  = 3,
   parameter bit HAS_AHI = 1'b1,
   parameter bit HAS_MSK = 1'b1,
   parameter int IDX_DAT = 3,
   parameter int IDX_MSK = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       ctl,
   input  logic [31:0]       alo,
   input  logic [31:0]       ahi,
   input  logic [31:0]       dat,
   input  logic [31:0]       msk,
   output logic [31:0]       rdata
);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_ALO = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_AHI = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(IDX_DAT);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(IDX_MSK);

   always_comb begin
      rdata = '0;
      if (addr == A_CTL)                 rdata = ctl;
      else if (addr == A_ALO)            rdata = alo;
      else if (HAS_AHI && addr == A_AHI) rdata = ahi;
      else if (addr == A_DAT)            rdata = dat;
      else if (HAS_MSK && addr == A_MSK) rdata = msk;
   end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter int         VEC_COUNT = 4,
   parameter bit         ADDR64    = 1'b1,
   parameter bit         PVMASK    = 1'b1,
   parameter int         ADDR_W    = 3,
   parameter logic [7:0] NEXT_PTR  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [63:0]       msg_addr,
   output logic [15:0]       msg_data,
   output logic              msi_enable,
   output logic [5:0]        alloc_count,
   output logic [31:0]       mask_bits
);
   localparam int           LOG2N   = f_log2(VEC_COUNT);
   localparam int           IDX_DAT = ADDR64 ? 3 : 2;
   localparam int           IDX_MSK = IDX_DAT + 1;
   localparam logic [31:0]  MSK_WMASK = f_vec_mask(VEC_COUNT);
   localparam logic [31:0]  CTL_CONST = {7'b0, PVMASK, ADDR64, 3'b000, 3'(LOG2N),
                                         1'b0, NEXT_PTR, 8'h05};

   initial begin
      assert (f_count_ok(VEC_COUNT)) else $error("VEC_COUNT must be 1,2,4,8,16 or 32");
      assert ((1 << ADDR_W) > IDX_MSK + 1) else $error("ADDR_W too small for layout");
   end

   logic [31:0] ctl_q, alo_q, ahi_q, dat_q, msk_q;
   logic [31:0] ctl_rd;

   function automatic logic f_sel(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   msi_cap_wreg #(.W(32), .WMASK(CTL_WMASK)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(cfg_wr && f_sel(cfg_addr, 0)),
      .be(cfg_be), .wdata(cfg_wdata), .q(ctl_q));

   msi_cap_wreg #(.W(32), .WMASK(ALO_WMASK)) u_alo (
      .clk(clk), .rst_n(rst_n), .we(cfg_wr && f_sel(cfg_addr, 1)),
      .be(cfg_be), .wdata(cfg_wdata), .q(alo_q));

   if (ADDR64) begin : g_ahi
      msi_cap_wreg #(.W(32), .WMASK(AHI_WMASK)) u_ahi (
         .clk(clk), .rst_n(rst_n), .we(cfg_wr && f_sel(cfg_addr, 2)),
         .be(cfg_be), .wdata(cfg_wdata), .q(ahi_q));
   end else begin : g_no_ahi
      assign ahi_q = '0;
   end

   msi_cap_wreg #(.W(32), .WMASK(DAT_WMASK)) u_dat (
      .clk(clk), .rst_n(rst_n), .we(cfg_wr && f_sel(cfg_addr, IDX_DAT)),
      .be(cfg_be), .wdata(cfg_wdata), .q(dat_q));

   if (PVMASK) begin : g_msk
      msi_cap_wreg #(.W(32), .WMASK(MSK_WMASK)) u_msk (
         .clk(clk), .rst_n(rst_n), .we(cfg_wr && f_sel(cfg_addr, IDX_MSK)),
         .be(cfg_be), .wdata(cfg_wdata), .q(msk_q));
   end else begin : g_no_msk
      assign msk_q = '0;
   end

   assign ctl_rd = CTL_CONST | ctl_q;

   msi_cap_rdmux #(
      .ADDR_W(ADDR_W), .HAS_AHI(ADDR64), .HAS_MSK(PVMASK),
      .IDX_DAT(IDX_DAT), .IDX_MSK(IDX_MSK)
   ) u_rdmux (
      .addr(cfg_addr), .ctl(ctl_rd), .alo(alo_q), .ahi(ahi_q),
      .dat(dat_q), .msk(msk_q), .rdata(cfg_rdata));

   logic [2:0] mme, eff;
   assign mme         = ctl_q[22:20];
   assign eff         = (mme > 3'(LOG2N)) ? 3'(LOG2N) : mme;
   assign alloc_count = 6'd1 << eff;

   assign msg_addr   = {ahi_q, alo_q};
   assign msg_data   = dat_q[15:0];
   assign msi_enable = ctl_q[16];
   assign mask_bits  = msk_q;

   // R1: identifier byte constant at dword 0
   a_r1_cap_id: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == '0) |-> (cfg_rdata[7:0] == 8'h05));
   // R2: enable follows a write of byte 2 of dword 0
   a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == '0 && cfg_be[2]) |=> (msi_enable == $past(cfg_wdata[16])));
   // R3: low address bits never set
   a_r3_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == ADDR_W'(1)) |-> (cfg_rdata[1:0] == 2'b00));
   // R6: mask bits above the vector count stay clear
   a_r6_mask_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_bits & ~MSK_WMASK) == '0);
   // R10: allocation never exceeds the capable count
   a_r10_alloc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_count <= 6'(VEC_COUNT)) && $onehot0(alloc_count));
endmodule

// File: tb/msi_cap_regs_bench.sv
module msi_cap_regs_bench;
   localparam int N   = 4;
   localparam bit A64 = 1'b1;
   localparam bit PVM = 1'b1;
   localparam int AW  = 3;
   localparam logic [7:0] NXT = 8'h48;
   localparam int L = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic cfg_wr = 1'b0;
   logic [3:0] cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata, mask_bits;
   logic [63:0] msg_addr;
   logic [15:0] msg_data;
   logic msi_enable;
   logic [5:0] alloc_count;

   int checks = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";
   logic [31:0] st [0:7];

   always #10 clk = ~clk;

   msi_cap_regs #(.VEC_COUNT(N), .ADDR64(A64), .PVMASK(PVM), .ADDR_W(AW), .NEXT_PTR(NXT))
   u_msi_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_addr(msg_addr),
      .msg_data(msg_data), .msi_enable(msi_enable), .alloc_count(alloc_count),
      .mask_bits(mask_bits));

   function automatic logic [31:0] wm(input int i);
      case (i)
         0: return 32'h0071_0000;
         1: return 32'hFFFF_FFFC;
         2: return A64 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
         3: return A64 ? 32'h0000_FFFF : (PVM ? 32'((1 << N) - 1) : 32'h0);
         4: return (A64 && PVM) ? 32'((1 << N) - 1) : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] rd_exp(input int i);
      logic [31:0] c;
      c = 0;
      if (i == 0) c = 32'h05 | (32'(NXT) << 8) | (32'(L) << 17) | (32'(A64) << 23) | (32'(PVM) << 24);
      return c | st[i];
   endfunction

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      int mme, eff;
      chk("rdata", 64'(cfg_rdata), 64'(rd_exp(int'(cfg_addr))));
      chk("msg_addr", msg_addr, {(A64 ? st[2] : 32'h0), st[1]});
      chk("msg_data", 64'(msg_data), 64'(A64 ? st[3][15:0] : st[2][15:0]));
      chk("msi_enable", 64'(msi_enable), 64'(st[0][16]));
      chk("mask_bits", 64'(mask_bits), 64'(PVM ? (A64 ? st[4] : st[3]) : 32'h0));
      mme = int'(st[0][22:20]);
      eff = (mme > L) ? L : mme;
      chk("alloc_count", 64'(alloc_count), 64'(1 << eff));
   endtask

   task automatic step(input int a, input bit w, input logic [3:0] be, input logic [31:0] d);
      cfg_addr = AW'(a); cfg_wr = w; cfg_be = be; cfg_wdata = d;
      @(posedge clk);
      if (w) for (int b = 0; b < 4; b++)
         if (be[b]) begin
            logic [7:0] m;
            m = wm(a) >> (8*b);
            st[a][8*b +: 8] = (st[a][8*b +: 8] & ~m) | (d[8*b +: 8] & m);
         end
      @(negedge clk);
      cfg_wr = 1'b0;
      compare();
   endtask

   initial begin
      for (int i = 0; i < 8; i++) st[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1/R7 reset";
      for (int i = 0; i < 8; i++) step(i, 0, 4'h0, 0);
      cur_req = "R1 R2 R3 R4 R5 R6 R7 all-ones";
      for (int i = 0; i < 8; i++) begin step(i, 1, 4'hF, 32'hFFFF_FFFF); step(i, 0, 4'h0, 0); end
      cur_req = "R8 partial byte enables";
      for (int i = 0; i < 5; i++)
         for (int b = 0; b < 4; b++) step(i, 1, 4'(1 << b), 32'h0000_0000);
      step(2, 1, 4'b0101, 32'hA5C3_3C5A);
      step(1, 1, 4'b1010, 32'h1234_5678);
      cur_req = "R10 allocated size";
      for (int m = 0; m < 8; m++) step(0, 1, 4'b0100, 32'((m << 20) | 32'h1_0000));
      cur_req = "R2 enable clear";
      step(0, 1, 4'b0100, 32'h0);
      cur_req = "R9 random";
      for (int k = 0; k < 300; k++) step($urandom_range(7, 0), 1, 4'($urandom), $urandom);
      cur_req = "R6 mask";
      step(4, 1, 4'hF, 32'hFFFF_FFF5);
      step(4, 1, 4'h1, 32'h0000_000A);
      cur_req = "R7 pending";
      step(5, 1, 4'hF, 32'hFFFF_FFFF);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule